// File: doc/BRIEF.md
# Oscillator Frequency Meter

The meter estimates the frequency of one of two free-running on-chip oscillators by counting its rising edges during a fixed window of reference-clock cycles. With a 26 MHz reference and a window of 1024 reference cycles, the frequency in Hz is the result multiplied by 26e6/1024. An optional pre-divider on the measured clock lowers the counting rate for fast oscillators.

Software first sets the enable input and selects clock-meter mode, the source and the divisor. It then pulses the start input. The run flag goes high, stays high for exactly one window, and clears itself when the new result is latched. A caller polls the run flag and reads the count once the flag is low. If enable is dropped during a run, the run is abandoned and the previous result is kept.

Edges are counted in the measured clock's own domain by a Gray-coded counter. Each reference cycle, that counter is synchronised into the reference domain and differenced. The per-cycle increments are summed with saturation, so a sample taken at any moment is a valid count.

Top module: `osc_meter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, run_o is 0 and count_o is 0.
- R2: A start_i pulse begins a run only when enable_i is 1, mode_i equals 2'b00 (clock-meter mode) and no run is in progress. Otherwise it is ignored: run_o stays 0 and count_o is unchanged.
- R3: Once a run begins, run_o is high for exactly 1024 reference cycles (2**WIN_LOG2) and then clears itself.
- R4: At the end of a run, count_o equals the number of prescaled rising edges of the selected oscillator during the window, within ±2.
- R5: src_sel_i = 0 measures osc_a_i and src_sel_i = 1 measures osc_b_i.
- R6: A div_i value of N divides the measured clock by N+1 before counting, so 0 means no division.
- R7: The count saturates at 2**RES_W-1 (4095 by default) instead of wrapping.
- R8: If enable_i is 0 in a cycle where run_o is 1, run_o is 0 in the next cycle and count_o keeps its previous value.
- R9: count_o changes only in the cycle where run_o falls at the end of a completed window. It holds through idle time, through aborted runs and while a new run is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | Reference clock (26 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| osc_a_i | input | 1 | First oscillator under measurement |
| osc_b_i | input | 1 | Second oscillator under measurement |
| enable_i | input | 1 | Meter enable; dropping it aborts a run |
| start_i | input | 1 | One-cycle start request |
| mode_i | input | 2 | Meter mode; 2'b00 selects clock measurement |
| src_sel_i | input | 1 | Source select: 0 = osc_a_i, 1 = osc_b_i |
| div_i | input | DIV_W | Pre-divider setting; divides by div_i+1 |
| run_o | output | 1 | Run flag; clears itself at the end of the window |
| count_o | output | RES_W | Latched edge count of the last completed window |

## Verification
A wrong window counter shows at the ports as a run flag whose length differs from 1024 cycles, and this is visible on the very first run. A wrong prescaler, source selection or Gray transfer shows as a count outside its ±2 band when the run flag falls. The same happens if an accumulator is missing saturation: a fast source then yields a small, wrapped count. A bad abort or hold path shows as count_o moving without a completed window; the move appears one cycle after enable drops, or at any idle point later.

// File: rtl/osc_meter_pkg.sv
package osc_meter_pkg;
  typedef enum logic [1:0] {
    MODE_CLK  = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } meter_mode_e;
endpackage

// File: rtl/osc_meter_src.sv
// Measured-clock domain: source mux, prescaler, Gray edge counter.
module osc_meter_src #(
  parameter int DIV_W = 8,
  parameter int CW    = 4
) (
  input  logic             rst_ni,
  input  logic             osc_a_i,
  input  logic             osc_b_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CW-1:0]    gray_o
);
  logic             meas_clk;
  logic [DIV_W-1:0] pre_q;
  logic [CW-1:0]    bin_q, bin_nx, gray_q;

  // src_sel_i and div_i are quasi-static: changed only while idle
  always_comb meas_clk = src_sel_i ? osc_b_i : osc_a_i;
  always_comb bin_nx   = bin_q + CW'(1);

  always_ff @(posedge meas_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      bin_q  <= '0;
      gray_q <= '0;
    end else if (pre_q >= div_i) begin
      pre_q  <= '0;
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end else begin
      pre_q  <= pre_q + DIV_W'(1);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/osc_meter_sync.sv
// Reference domain: Gray synchroniser, decode, per-cycle increment.
module osc_meter_sync #(
  parameter int CW     = 4,
  parameter int SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] delta_o
);
  logic [CW-1:0] stg_q [SYNC_N];
  logic [CW-1:0] bin, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_N; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < SYNC_N; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= bin;
    end
  end

  always_comb begin
    bin[CW-1] = stg_q[SYNC_N-1][CW-1];
    for (int i = CW - 2; i >= 0; i--) bin[i] = bin[i+1] ^ stg_q[SYNC_N-1][i];
  end

  // modulo difference; valid while increments per cycle stay below 2**CW
  assign delta_o = bin - prev_q;
endmodule

// File: rtl/osc_meter_window.sv
// Reference domain: run control, window timer, saturating accumulator.
module osc_meter_window
  import osc_meter_pkg::*;
#(
  parameter int WIN_LOG2 = 10,
  parameter int RES_W    = 12,
  parameter int CW       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [CW-1:0]    delta_i,
  output logic             run_o,
  output logic [RES_W-1:0] count_o
);
  localparam logic [WIN_LOG2-1:0] WIN_LAST = {WIN_LOG2{1'b1}};
  localparam logic [RES_W:0]      RES_MAX  = {1'b0, {RES_W{1'b1}}};

  logic                run_q;
  logic [WIN_LOG2-1:0] win_q;
  logic [RES_W-1:0]    acc_q, res_q, acc_nx;
  logic [RES_W:0]      sum;
  logic                go;

  assign go  = start_i && enable_i && (mode_i == MODE_CLK) && !run_q;
  assign sum = {1'b0, acc_q} + {{(RES_W + 1 - CW){1'b0}}, delta_i};

  always_comb acc_nx = (sum > RES_MAX) ? RES_MAX[RES_W-1:0] : sum[RES_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      win_q <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else if (go) begin
      run_q <= 1'b1;
      win_q <= '0;
      acc_q <= '0;
    end else if (run_q) begin
      if (!enable_i) begin
        run_q <= 1'b0;
      end else if (win_q == WIN_LAST) begin
        run_q <= 1'b0;
        res_q <= acc_nx;
      end else begin
        win_q <= win_q + WIN_LOG2'(1);
        acc_q <= acc_nx;
      end
    end
  end

  assign run_o   = run_q;
  assign count_o = res_q;
endmodule

// File: rtl/osc_meter.sv
module osc_meter #(
  parameter int WIN_LOG2 = 10,
  parameter int RES_W    = 12,
  parameter int DIV_W    = 8,
  parameter int CW       = 4,
  parameter int SYNC_N   = 2
) (
  input  logic             clk_ref_i,
  input  logic             rst_ni,
  input  logic             osc_a_i,
  input  logic             osc_b_i,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic [RES_W-1:0] count_o
);
  logic [CW-1:0] gray;
  logic [CW-1:0] delta;

  osc_meter_src #(.DIV_W(DIV_W), .CW(CW)) u_src (
    .rst_ni   (rst_ni),
    .osc_a_i  (osc_a_i),
    .osc_b_i  (osc_b_i),
    .src_sel_i(src_sel_i),
    .div_i    (div_i),
    .gray_o   (gray)
  );

  osc_meter_sync #(.CW(CW), .SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .gray_i (gray),
    .delta_o(delta)
  );

  osc_meter_window #(.WIN_LOG2(WIN_LOG2), .RES_W(RES_W), .CW(CW)) u_win (
    .clk_i   (clk_ref_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .start_i (start_i),
    .mode_i  (mode_i),
    .delta_i (delta),
    .run_o   (run_o),
    .count_o (count_o)
  );
endmodule

// File: rtl/osc_meter_chk.sv
module osc_meter_chk #(
  parameter int WIN_LOG2 = 10,
  parameter int RES_W    = 12
) (
  input logic             clk_ref_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic             run_o,
  input logic [RES_W-1:0] count_o
);
  localparam int WIN = 2 ** WIN_LOG2;

  logic [WIN_LOG2:0] len_q;
  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else         len_q <= run_o ? len_q + 1'b1 : '0;
  end

  p_start_gate_r2: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (!run_o && start_i && (!enable_i || mode_i != 2'b00)) |=> !run_o);

  p_start_go_r2: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (!run_o && start_i && enable_i && mode_i == 2'b00) |=> run_o);

  p_win_len_r3: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    ($fell(run_o) && $past(enable_i)) |-> (len_q == (WIN_LOG2 + 1)'(WIN)));

  p_abort_r8: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (run_o && !enable_i) |=> (!run_o && $stable(count_o)));

  p_hold_r9: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    !$stable(count_o) |-> ($past(run_o) && !run_o));
endmodule

bind osc_meter osc_meter_chk #(.WIN_LOG2(WIN_LOG2), .RES_W(RES_W)) u_chk (
  .clk_ref_i(clk_ref_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .start_i  (start_i),
  .mode_i   (mode_i),
  .run_o    (run_o),
  .count_o  (count_o)
);

// File: tb/osc_meter_test.sv
`timescale 1ns/1ps
module osc_meter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 1024;

  typedef struct packed {
    logic [3:0]  half_a;
    logic [3:0]  half_b;
    logic        src;
    logic [7:0]  div;
    logic [11:0] exp;
  } vec_t;

  // ref period 10 ns: count = 1024*10/(2*half*(div+1))
  localparam vec_t VECS [7] = '{
    '{4'd2, 4'd4, 1'b0, 8'd0,   12'd2560},
    '{4'd2, 4'd4, 1'b1, 8'd0,   12'd1280},
    '{4'd2, 4'd4, 1'b0, 8'd1,   12'd1280},
    '{4'd2, 4'd4, 1'b1, 8'd3,   12'd320},
    '{4'd2, 4'd4, 1'b1, 8'd2,   12'd427},
    '{4'd2, 4'd4, 1'b0, 8'd255, 12'd10},
    '{4'd1, 4'd4, 1'b0, 8'd0,   12'd4095}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_a = 1'b0, osc_b = 1'b0;
  logic        enable = 1'b0, start = 1'b0, src_sel = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  div = '0;
  logic        run;
  logic [11:0] count;
  int          half_a = 2, half_b = 4;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always #(half_a) osc_a = ~osc_a;
  always #(half_b) osc_b = ~osc_b;

  osc_meter uut (
    .clk_ref_i(clk), .rst_ni(rst_n), .osc_a_i(osc_a), .osc_b_i(osc_b),
    .enable_i(enable), .start_i(start), .mode_i(mode), .src_sel_i(src_sel),
    .div_i(div), .run_o(run), .count_o(count)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // start a run and return the number of cycles run stayed high
  task automatic do_run(output int len);
    len = 0;
    pulse_start();
    while (run && len < 3000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int len, diff, held;
    idle(3);
    chk("R1 run in reset", run == 1'b0, run, 0);
    chk("R1 count in reset", count == 12'd0, count, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 run after reset", run == 1'b0, run, 0);
    chk("R1 count after reset", count == 12'd0, count, 0);

    enable = 1'b1;
    for (int i = 0; i < 7; i++) begin
      half_a  = int'(VECS[i].half_a);
      half_b  = int'(VECS[i].half_b);
      src_sel = VECS[i].src;
      div     = VECS[i].div;
      idle(20);
      do_run(len);
      chk("R3 run length", len == WIN, len, WIN);
      diff = int'(count) - int'(VECS[i].exp);
      if (VECS[i].exp == 12'd4095)
        chk("R7 saturated count", count == 12'd4095, count, 4095);
      else
        chk("R4 R5 R6 count", diff <= 2 && diff >= -2, count, VECS[i].exp);
    end
    half_a = 2;
    idle(20);

    held = int'(count);
    // R2: start without enable
    enable = 1'b0;
    pulse_start();
    chk("R2 start ignored when disabled", run == 1'b0, run, 0);
    idle(3);
    chk("R2 count unchanged when disabled", count == 12'(held), count, held);

    // R2: start with wrong mode
    enable = 1'b1;
    mode = 2'b01;
    pulse_start();
    chk("R2 start ignored in other mode", run == 1'b0, run, 0);
    mode = 2'b00;

    // R8: abort mid-run
    src_sel = 1'b0;
    div = 8'd0;
    idle(20);
    pulse_start();
    chk("R2 run begins", run == 1'b1, run, 1);
    idle(100);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk("R8 run cleared on abort", run == 1'b0, run, 0);
    chk("R8 count kept on abort", count == 12'(held), count, held);
    idle(1100);
    chk("R9 count held after abort", count == 12'(held), count, held);

    // R9: result holds during a fresh run, then updates at the end
    enable = 1'b1;
    pulse_start();
    idle(500);
    chk("R9 count held mid-run", count == 12'(held) && run, count, held);
    while (run) @(negedge clk);
    diff = int'(count) - 2560;
    chk("R4 count after new run", diff <= 2 && diff >= -2, count, 2560);

    // R3: start while running is ignored, window length unchanged
    len = 0;
    pulse_start();
    idle(10);
    len = 11;
    pulse_start();
    len++;
    while (run && len < 3000) begin
      len++;
      @(negedge clk);
    end
    chk("R3 restart ignored", len == WIN, len, WIN);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule